// File: doc/BRIEF.md
# Timer with Dual Input Capture

A 16-bit up-counting timer whose count can be frozen into two capture registers, either by hardware edges or by a software strobe. A small synchronous register bus holds two locations: a mode register and a compare register. The mode register picks what advances the counter. The choices are edges on an external pin or one of three prescaled tick enables. The mode register also decides whether the counter returns to zero when it equals the compare value, and which edges load which capture register. The prescaler and the companion timer sit outside this block. Their outputs arrive as single-cycle tick enables and as a trigger level.

The external pin and the companion trigger each pass through a two-flop synchroniser before edge detection. When a hardware capture is selected, a rising edge loads capture register 0 and, in the two-edge modes, a falling edge loads capture register 1. A single-cycle interrupt pulse follows the pin edge that the capture mode calls for. Writing the mode register with its strobe bit at 0 copies the counter into capture register 0 at that write. For this reason, software must always write the whole mode register and never build a new value by reading the old one back.

Top module: `cap_timer`

## Requirements
- R1: After reset the counter, both capture registers, the interrupt output and every mode field read 0.
- R2: The clock-source field (mode bits 1:0) selects the count enable: 00 pin rising edges, 01 tick_t1_i, 10 tick_t4_i, 11 tick_t16_i. The counter advances by one per selected enable and ignores the other sources.
- R3: With source 00 the counter advances once per rising edge of the synchronised pin.
- R4: With clear-enable (mode bit 2) at 1, a count enable that finds the counter equal to the compare register sets the counter to 0 instead of incrementing it. With clear-enable at 0 the counter wraps from 0xFFFF to 0.
- R5: Capture mode 00 (mode bits 4:3) loads neither capture register from hardware edges.
- R6: Capture mode 01 loads capture register 0 with the counter on a pin rising edge, three clocks after the pin changes. Capture register 1 is left untouched.
- R7: Capture mode 10 loads capture register 0 on pin rising edges and capture register 1 on pin falling edges.
- R8: Capture mode 11 loads capture register 0 on trigger rising edges and capture register 1 on trigger falling edges. Pin edges capture nothing in this mode.
- R9: A mode write with bit 5 at 0 loads capture register 0 with the counter value present at that write edge. A mode write with bit 5 at 1 captures nothing.
- R10: irq_o is a one-cycle pulse, in the same cycle the capture register shows its new value. It follows a pin rising edge in capture modes 00, 01 and 11, and a pin falling edge in mode 10. Trigger edges never raise it.
- R11: The mode register (address 0) reads back with bits 15:5 at 0. Bits 7:5 hold no state. The compare register (address 1) reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 mode, 1 compare |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| cap_pin_i | input | 1 | External capture / count pin (asynchronous) |
| trig_i | input | 1 | Companion timer output (asynchronous) |
| tick_t1_i | input | 1 | Prescaled tick enable T1 |
| tick_t4_i | input | 1 | Prescaled tick enable T4 |
| tick_t16_i | input | 1 | Prescaled tick enable T16 |
| cnt_o | output | 16 | Counter value |
| cap0_o | output | 16 | Capture register 0 |
| cap1_o | output | 16 | Capture register 1 |
| irq_o | output | 1 | Interrupt pulse |

## Verification
A hardware capture and a clear-on-match can act on the same clock edge. In that case capture register 0 must hold the matched value, and the counter must read zero. The bench advances the counter to the compare value with manual T4 ticks and raises the pin. It then asserts one T4 tick exactly in the cycle before the synchronised edge is consumed. Afterwards it checks that capture register 0 equals the compare value and that the counter reads 0. The mode, source and edge sweeps cover every combination of capture mode and edge source.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SRC_PIN = 2'b00,
    SRC_T1  = 2'b01,
    SRC_T4  = 2'b10,
    SRC_T16 = 2'b11
  } src_e;

  typedef enum logic [1:0] {
    CAP_OFF       = 2'b00,
    CAP_PIN_RISE  = 2'b01,
    CAP_PIN_BOTH  = 2'b10,
    CAP_TRIG_BOTH = 2'b11
  } cap_e;

  typedef struct packed {
    cap_e cap;
    logic clr_en;
    src_e src;
  } mode_t;

  localparam int SRC_LSB   = 0;
  localparam int CLR_BIT   = 2;
  localparam int CAP_LSB   = 3;
  localparam int SWCAP_BIT = 5;
  localparam int MODE_W    = $bits(mode_t);
  localparam int NUM_CAP   = 2;
endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[LAST];
  end

  assign rise_o = sync_q[LAST] & ~prev_q;
  assign fall_o = ~sync_q[LAST] & prev_q;
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_en_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  assign hit = clr_en_i && (cnt_q == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (en_i) begin
      // clear wins over increment; natural wrap otherwise
      if (hit) cnt_q <= '0;
      else     cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_cap_route.sv
module tmr_cap_route
  import tmr_pkg::*;
(
  input  cap_e                 cap_i,
  input  logic                 sw_cap_i,
  input  logic                 pin_rise_i,
  input  logic                 pin_fall_i,
  input  logic                 trig_rise_i,
  input  logic                 trig_fall_i,
  output logic [NUM_CAP-1:0]   ld_o,
  output logic                 irq_evt_o
);
  logic hw0, hw1;

  always_comb begin
    hw0 = 1'b0;
    hw1 = 1'b0;
    unique case (cap_i)
      CAP_OFF:       ;
      CAP_PIN_RISE:  hw0 = pin_rise_i;
      CAP_PIN_BOTH:  begin hw0 = pin_rise_i;  hw1 = pin_fall_i;  end
      CAP_TRIG_BOTH: begin hw0 = trig_rise_i; hw1 = trig_fall_i; end
      default:       ;
    endcase
  end

  // software strobe and hardware both load the live count; strobe has priority
  assign ld_o[0]   = sw_cap_i | hw0;
  assign ld_o[1]   = hw1;
  assign irq_evt_o = (cap_i == CAP_PIN_BOTH) ? pin_fall_i : pin_rise_i;
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic             cap_pin_i,
  input  logic             trig_i,
  input  logic             tick_t1_i,
  input  logic             tick_t4_i,
  input  logic             tick_t16_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap0_o,
  output logic [CNT_W-1:0] cap1_o,
  output logic             irq_o
);
  localparam logic ADDR_MODE = 1'b0;
  localparam logic ADDR_CMP  = 1'b1;

  mode_t            mode_q;
  logic [CNT_W-1:0] cmp_q;
  logic             wr_mode, wr_cmp, sw_cap;
  logic             pin_rise, pin_fall, trig_rise, trig_fall;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt;
  logic [NUM_CAP-1:0] ld;
  logic             irq_evt, irq_q;
  logic [CNT_W-1:0] cap_q [NUM_CAP];

  assign wr_mode = wr_en_i && (addr_i == ADDR_MODE);
  assign wr_cmp  = wr_en_i && (addr_i == ADDR_CMP);
  assign sw_cap  = wr_mode && !wdata_i[SWCAP_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '{cap: CAP_OFF, clr_en: 1'b0, src: SRC_PIN};
    end else if (wr_mode) begin
      mode_q.src    <= src_e'(wdata_i[SRC_LSB +: 2]);
      mode_q.clr_en <= wdata_i[CLR_BIT];
      mode_q.cap    <= cap_e'(wdata_i[CAP_LSB +: 2]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmp_q <= '0;
    else if (wr_cmp) cmp_q <= wdata_i;
  end

  assign rdata_o = (addr_i == ADDR_MODE) ? CNT_W'(mode_q) : cmp_q;

  tmr_edge_det #(.STAGES(SYNC_STAGES)) u_pin_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cap_pin_i),
    .rise_o(pin_rise),
    .fall_o(pin_fall)
  );

  tmr_edge_det #(.STAGES(SYNC_STAGES)) u_trig_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (trig_i),
    .rise_o(trig_rise),
    .fall_o(trig_fall)
  );

  always_comb begin
    unique case (mode_q.src)
      SRC_PIN: cnt_en = pin_rise;
      SRC_T1:  cnt_en = tick_t1_i;
      SRC_T4:  cnt_en = tick_t4_i;
      SRC_T16: cnt_en = tick_t16_i;
      default: cnt_en = 1'b0;
    endcase
  end

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (cnt_en),
    .clr_en_i(mode_q.clr_en),
    .cmp_i   (cmp_q),
    .cnt_o   (cnt)
  );

  tmr_cap_route u_route (
    .cap_i      (mode_q.cap),
    .sw_cap_i   (sw_cap),
    .pin_rise_i (pin_rise),
    .pin_fall_i (pin_fall),
    .trig_rise_i(trig_rise),
    .trig_fall_i(trig_fall),
    .ld_o       (ld),
    .irq_evt_o  (irq_evt)
  );

  generate
    for (genvar c = 0; c < NUM_CAP; c++) begin : g_cap
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   cap_q[c] <= '0;
        else if (ld[c]) cap_q[c] <= cnt;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_evt;
  end

  assign cnt_o  = cnt;
  assign cap0_o = cap_q[0];
  assign cap1_o = cap_q[1];
  assign irq_o  = irq_q;
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       cap_mode_i,
  input logic             clr_en_i,
  input logic             cnt_en_i,
  input logic             sw_cap_i,
  input logic             pin_fall_i,
  input logic [CNT_W-1:0] cmp_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] cap0_i,
  input logic [CNT_W-1:0] cap1_i,
  input logic             irq_i
);
  // R2
  count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i |=> $stable(cnt_i));

  // R4
  clear_on_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && clr_en_i && cnt_i == cmp_i) |=> (cnt_i == '0));

  // R4
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !clr_en_i && cnt_i == {CNT_W{1'b1}}) |=> (cnt_i == '0));

  // R5
  cap1_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_mode_i[1] == 1'b0) |=> $stable(cap1_i));

  // R7
  cap1_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_mode_i == 2'b10 && pin_fall_i) |=> (cap1_i == $past(cnt_i)));

  // R9
  sw_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_cap_i |=> (cap0_i == $past(cnt_i)));

  // R10
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !irq_i);
endmodule

bind cap_timer cap_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cap_mode_i(mode_q.cap),
  .clr_en_i  (mode_q.clr_en),
  .cnt_en_i  (cnt_en),
  .sw_cap_i  (sw_cap),
  .pin_fall_i(pin_fall),
  .cmp_i     (cmp_q),
  .cnt_i     (cnt),
  .cap0_i    (cap0_o),
  .cap1_i    (cap1_o),
  .irq_i     (irq_o)
);

// File: tb/cap_timer_test.sv
module cap_timer_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic        addr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        pin = 1'b0, trig = 1'b0;
  logic        t1 = 1'b0, t4 = 1'b0, t16 = 1'b0;
  logic [15:0] cnt, cap0, cap1;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  cap_timer uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cap_pin_i(pin), .trig_i(trig),
    .tick_t1_i(t1), .tick_t4_i(t4), .tick_t16_i(t16),
    .cnt_o(cnt), .cap0_o(cap0), .cap1_o(cap1), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int src, input int clr, input int cm, input int swn);
    return 16'((swn << 5) | (cm << 3) | (clr << 2) | src);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; pin = 0; trig = 0; t1 = 0; t4 = 0; t16 = 0; wr_en = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 1'b0;
  endtask

  task automatic tick(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (which)
        1: t1 = 1'b1;
        2: t4 = 1'b1;
        default: t16 = 1'b1;
      endcase
      @(negedge clk);
      t1 = 1'b0; t4 = 1'b0; t16 = 1'b0;
    end
  endtask

  // drive one edge, check the interrupt pulse three clocks later
  task automatic edge_drv(input bit on_trig, input bit val, input bit exp_irq, input string req);
    @(negedge clk);
    if (on_trig) trig = val; else pin = val;
    repeat (3) @(negedge clk);
    chk(req, {15'b0, irq}, {15'b0, exp_irq});
    @(negedge clk);
    chk("R10 pulse width", {15'b0, irq}, 16'h0);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog expired (all requirements) actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1
    chk("R1 counter", cnt, 16'h0);
    chk("R1 cap0", cap0, 16'h0);
    chk("R1 cap1", cap1, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);
    addr = 1'b0; #1;
    chk("R1 mode", rdata, 16'h0);

    // R11 readback, R9 strobe at 1 captures nothing
    wr(1'b0, 16'hFFFF);
    addr = 1'b0; #1;
    chk("R11 mode readback", rdata, 16'h001F);
    chk("R9 strobe=1 no capture", cap0, 16'h0);
    wr(1'b1, 16'hABCD);
    addr = 1'b1; #1;
    chk("R11 compare readback", rdata, 16'hABCD);

    // R2 source sweep
    for (int s = 0; s < 4; s++) begin
      int exp_c;
      do_reset();
      wr(1'b0, mk(s, 0, 0, 1));
      tick(1, 3); tick(2, 5); tick(3, 7);
      exp_c = (s == 1) ? 3 : (s == 2) ? 5 : (s == 3) ? 7 : 0;
      chk($sformatf("R2 source %0d", s), cnt, 16'(exp_c));
    end

    // R3 pin edge counting
    do_reset();
    wr(1'b0, mk(0, 0, 0, 1));
    for (int k = 0; k < 9; k++) begin
      @(negedge clk); pin = 1'b1;
      repeat (4) @(negedge clk);
      pin = 1'b0;
      repeat (4) @(negedge clk);
    end
    chk("R3 pin edges counted", cnt, 16'd9);

    // R5..R8, R10 capture mode x edge source sweep
    for (int cm = 0; cm < 4; cm++) begin
      for (int tr = 0; tr < 2; tr++) begin
        int v1, v2;
        logic [15:0] e0, e1;
        do_reset();
        wr(1'b0, mk(2, 0, cm, 1));
        v1 = cm * 4 + tr + 2;
        tick(2, v1);
        edge_drv(tr[0], 1'b1, (tr == 0) && (cm != 2), "R10 rise irq");
        e0 = (((cm == 1 || cm == 2) && tr == 0) || (cm == 3 && tr == 1)) ? 16'(v1) : 16'h0;
        chk($sformatf("R5-8 mode%0d src%0d rise cap0", cm, tr), cap0, e0);
        chk($sformatf("R5-8 mode%0d src%0d rise cap1", cm, tr), cap1, 16'h0);
        tick(2, 3);
        v2 = v1 + 3;
        edge_drv(tr[0], 1'b0, (tr == 0) && (cm == 2), "R10 fall irq");
        e1 = ((cm == 2 && tr == 0) || (cm == 3 && tr == 1)) ? 16'(v2) : 16'h0;
        chk($sformatf("R7/R8 mode%0d src%0d fall cap1", cm, tr), cap1, e1);
        chk($sformatf("R6 mode%0d src%0d fall keeps cap0", cm, tr), cap0, e0);
      end
    end

    // R9 software capture
    do_reset();
    wr(1'b0, mk(2, 0, 0, 1));
    tick(2, 6);
    wr(1'b0, mk(2, 0, 0, 0));
    chk("R9 strobe=0 captures", cap0, 16'd6);
    tick(2, 2);
    wr(1'b0, mk(2, 0, 0, 1));
    chk("R9 strobe=1 keeps cap0", cap0, 16'd6);
    chk("R9 counter unaffected", cnt, 16'd8);

    // R4 clear on match, every step
    do_reset();
    wr(1'b1, 16'd5);
    wr(1'b0, mk(1, 1, 0, 1));
    @(negedge clk); t1 = 1'b1;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      chk($sformatf("R4 clear step %0d", i), cnt, 16'(i % 6));
    end
    t1 = 1'b0;

    // R4 wrap with clear disabled
    do_reset();
    wr(1'b1, 16'd5);
    wr(1'b0, mk(1, 0, 0, 1));
    @(negedge clk); t1 = 1'b1;
    repeat (65535) @(negedge clk);
    chk("R4 reaches max", cnt, 16'hFFFF);
    @(negedge clk);
    t1 = 1'b0;
    chk("R4 wrap to zero", cnt, 16'h0);

    // R4 + R6 coincidence: capture on the clearing edge
    do_reset();
    wr(1'b1, 16'd4);
    wr(1'b0, mk(2, 1, 1, 1));
    tick(2, 4);
    @(negedge clk); pin = 1'b1;
    repeat (2) @(negedge clk);
    t4 = 1'b1;
    @(negedge clk);
    t4 = 1'b0;
    chk("R6 capture on clear edge", cap0, 16'd4);
    chk("R4 cleared on same edge", cnt, 16'h0);
    chk("R10 irq with capture", {15'b0, irq}, 16'h1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule